// File: doc/BRIEF.md
# Capture/Compare Timer Status Flags

This block holds a free-running up-counter and three general registers, channels B, C and D. A mode input chooses, per channel, whether its general register captures the counter or is compared against it. A captured counter value, or a counter that steps onto the register's value, raises that channel's status flag. Each flag drives an interrupt request through its own enable bit.

Software reaches the counter, the general registers, the flag register and the enable register over a simple strobe bus. A flag can be cleared only by a handshake. First a read of the flag register must return the flag as 1. Then a write must put 0 in that bit. Any other write leaves the flag alone. Capture inputs may be asynchronous, so they pass through a synchroniser before the rising-edge detector.

Top module: `cc_timer_flags`

## Requirements
- R1: Register addresses are 0 for flags, 1 for interrupt enables, 2 for the counter, and 3, 4 and 5 for general registers B, C and D. In both the flag and enable registers, channel B sits at bit 1, C at bit 2 and D at bit 3.
- R2: After reset every flag, enable, general register and the counter are 0, and every irq_o bit is 0.
- R3: In capture mode (cap_mode_i bit = 1), a rising edge on the channel's cap_i copies the counter into its general register and sets its flag on the third rising clock edge after the input changes.
- R4: A capture input held high captures only once. A capture edge on a channel in compare mode changes neither its register nor its flag.
- R5: In compare mode, the flag sets on the clock edge where the counter increments onto a value equal to the general register.
- R6: While the counter is stalled at a matching value, a cleared compare flag does not set again.
- R7: Writing 0 to a flag bit after a flag-register read has returned that bit as 1 clears the flag.
- R8: Writing 0 to a flag not read as 1 since it last set has no effect. Writing 1 to a flag bit has no effect.
- R9: When a set condition and a valid clear write fall in the same cycle, the flag stays 1. The clear attempt still uses up the read marker.
- R10: irq_o bit i is the flag of channel i ANDed with its enable bit.
- R11: Flag and enable bits 0 and 4 and above read 0, and writes to them are ignored.
- R12: Read data appears on rdata_o one clock cycle after the rd_i strobe and holds until the next read.
- R13: The counter increments on each cycle with cnt_en_i high. A bus write loads it, and the write wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter increment enable |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| cap_i | input | 3 | Capture inputs, index 0 = B, 1 = C, 2 = D |
| cap_mode_i | input | 3 | Per-channel mode, 1 = capture, 0 = compare |
| irq_o | output | 3 | Per-channel interrupt requests, index 0 = B |

## Verification
A capture result is due on the third clock edge after cap_i changes. A compare flag is due on the same edge that moves the counter onto the register value. A flag-register write acts on the edge that samples it. irq_o follows the flag register with no extra delay, so the bench reads it at the falling edge after each of those edges and confirms that capture is still 0 one and two edges in. Register reads go through a scoreboard: the driver queues the expected word with the strobe, and the monitor compares it at the falling edge one cycle later.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int NUM_CH   = 3;
  localparam int FLAG_LSB = 1;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd2;
  localparam int                GR_BASE  = 3;
endpackage

// File: rtl/ccf_counter.sv
module ccf_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         inc_o
);
  logic [W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + W'(1);
  assign inc_o     = en_i & ~ld_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (en_i)  cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/ccf_cap_edge.sv
module ccf_cap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ccf_channel.sv
module ccf_channel #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_mode_i,
  input  logic         cap_rise_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic         cnt_inc_i,
  input  logic         gr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         stat_rd_i,
  input  logic         stat_wr_i,
  input  logic         wbit_i,
  output logic [W-1:0] gr_o,
  output logic         flag_o
);
  logic [W-1:0] gr_q;
  logic         flag_q, seen_q;
  logic         cap_hit, cmp_hit, set_req, clr_try;

  assign cap_hit = cap_mode_i & cap_rise_i;
  // compare against the value the counter is stepping onto
  assign cmp_hit = ~cap_mode_i & cnt_inc_i & (cnt_nxt_i == gr_q);
  assign set_req = cap_hit | cmp_hit;
  assign clr_try = stat_wr_i & ~wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gr_q <= '0;
    else if (cap_hit)  gr_q <= cnt_i;
    else if (gr_wr_i)  gr_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  seen_q <= 1'b0;
    else if (clr_try)             seen_q <= 1'b0;
    else if (stat_rd_i && flag_q) seen_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (set_req)            flag_q <= 1'b1;
    else if (clr_try && seen_q)  flag_q <= 1'b0;
  end

  assign gr_o   = gr_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cc_timer_flags.sv
module cc_timer_flags
  import ccf_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] cap_i,
  input  logic [NUM_CH-1:0] cap_mode_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [CNT_W-1:0]              cnt_q, cnt_nxt;
  logic                          cnt_inc;
  logic [NUM_CH-1:0]             flag_q, ien_q, cap_rise;
  logic [NUM_CH-1:0][CNT_W-1:0]  gr_q;
  logic [CNT_W-1:0]              rd_mux, rdata_q;
  logic                          stat_rd, stat_wr;

  assign stat_rd = rd_i & (addr_i == ADR_STAT);
  assign stat_wr = wr_i & (addr_i == ADR_STAT);

  ccf_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .ld_i     (wr_i & (addr_i == ADR_CNT)),
    .ld_val_i (wdata_i),
    .cnt_o    (cnt_q),
    .cnt_nxt_o(cnt_nxt),
    .inc_o    (cnt_inc)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ccf_cap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .din_i (cap_i[g]),
      .rise_o(cap_rise[g])
    );

    ccf_channel #(.W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_mode_i(cap_mode_i[g]),
      .cap_rise_i(cap_rise[g]),
      .cnt_i     (cnt_q),
      .cnt_nxt_i (cnt_nxt),
      .cnt_inc_i (cnt_inc),
      .gr_wr_i   (wr_i & (addr_i == ADDR_W'(GR_BASE + g))),
      .wdata_i   (wdata_i),
      .stat_rd_i (stat_rd),
      .stat_wr_i (stat_wr),
      .wbit_i    (wdata_i[FLAG_LSB+g]),
      .gr_o      (gr_q[g]),
      .flag_o    (flag_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ien_q <= '0;
    else if (wr_i && addr_i == ADR_IEN)   ien_q <= wdata_i[FLAG_LSB +: NUM_CH];
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADR_STAT: rd_mux[FLAG_LSB +: NUM_CH] = flag_q;
      ADR_IEN:  rd_mux[FLAG_LSB +: NUM_CH] = ien_q;
      ADR_CNT:  rd_mux = cnt_q;
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (addr_i == ADDR_W'(GR_BASE + i)) rd_mux = gr_q[i];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = flag_q & ien_q;
endmodule

// File: rtl/ccf_checker.sv
module ccf_checker
  import ccf_pkg::*;
#(
  parameter int W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        addr_i,
  input logic                     rd_i,
  input logic                     wr_i,
  input logic [W-1:0]             wdata_i,
  input logic [W-1:0]             rdata_o,
  input logic [NUM_CH-1:0]        cap_mode_i,
  input logic [NUM_CH-1:0]        flag_i,
  input logic [W-1:0]             cnt_i,
  input logic [NUM_CH-1:0][W-1:0] gr_i
);
  always @(posedge clk_i)
    if (!rst_ni) AST_RST_FLAGS_ZERO: assert (flag_i == '0); // R2

  AST_STAT_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && addr_i == ADR_STAT) |->
      (rdata_o[0] == 1'b0 && rdata_o[W-1:FLAG_LSB+NUM_CH] == '0)); // R11

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
    AST_CLEAR_NEEDS_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_i[g]) |->
        $past(wr_i && addr_i == ADR_STAT && !wdata_i[FLAG_LSB+g])); // R7

    AST_CAPTURE_COPIES_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flag_i[g]) && $past(cap_mode_i[g])) |-> (gr_i[g] == $past(cnt_i))); // R3

    AST_COMPARE_ON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flag_i[g]) && !$past(cap_mode_i[g])) |->
        (cnt_i != $past(cnt_i) && cnt_i == gr_i[g])); // R6
  end
endmodule

bind cc_timer_flags ccf_checker #(.W(CNT_W)) u_ccf_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .cap_mode_i(cap_mode_i),
  .flag_i    (flag_q),
  .cnt_i     (cnt_q),
  .gr_i      (gr_q)
);

// File: tb/cc_timer_flags_bench.sv
module cc_timer_flags_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [2:0] A_STAT = 3'd0, A_IEN = 3'd1, A_CNT = 3'd2;
  localparam logic [2:0] A_GRB = 3'd3, A_GRC = 3'd4, A_GRD = 3'd5;

  logic        clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0, cap = '0, cap_mode = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  irq;

  cc_timer_flags u_cc_timer_flags (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .cap_i(cap), .cap_mode_i(cap_mode), .irq_o(irq)
  );

  always #10ns clk = ~clk;

  typedef struct {logic [15:0] d; string tag;} exp_t;
  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  logic rd_seen = 1'b0;

  function automatic void check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  always @(posedge clk) rd_seen <= rd;

  // monitor: read data is due one cycle after the strobe
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) check("R12 unexpected read", rdata, 16'hxxxx);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rdata, e.d);
      end
    end
  end

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, logic [15:0] e, string tag);
    exp_t x;
    x.d = e; x.tag = tag;
    exp_q.push_back(x);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_en();
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R2 irq after reset", {13'd0, irq}, 16'h0000);
    rd_reg(A_STAT, 16'h0000, "R2 flags after reset");
    rd_reg(A_IEN,  16'h0000, "R2 enables after reset");
    rd_reg(A_CNT,  16'h0000, "R2 counter after reset");
    rd_reg(A_GRB,  16'h0000, "R2 GR B after reset");

    wr_reg(A_IEN, 16'hFFFF);
    rd_reg(A_IEN, 16'h000E, "R11 enable unused bits");
    wr_reg(A_IEN, 16'h0000);

    // compare on channel B
    wr_reg(A_CNT, 16'h0013);
    wr_reg(A_GRB, 16'h0014);
    rd_reg(A_STAT, 16'h0000, "R5 no match before step");
    pulse_en();
    wr_reg(A_STAT, 16'h0000);
    rd_reg(A_STAT, 16'h0002, "R1/R5 flag B at bit 1, R8 unread zero write");
    wr_reg(A_STAT, 16'h0002);
    rd_reg(A_STAT, 16'h0002, "R8 write of one");
    wr_reg(A_STAT, 16'h0000);
    rd_reg(A_STAT, 16'h0000, "R7 handshake clear");
    rd_reg(A_CNT,  16'h0014, "R13 counter stepped");
    idle(5);
    rd_reg(A_STAT, 16'h0000, "R6 stalled match");

    // set wins over clear
    wr_reg(A_IEN, 16'h0002);
    wr_reg(A_CNT, 16'h0013);
    pulse_en();
    check("R10 irq B follows flag", {13'd0, irq}, 16'h0001);
    rd_reg(A_STAT, 16'h0002, "R9 flag set before race");
    wr_reg(A_CNT, 16'h0013);
    cnt_en = 1'b1; addr = A_STAT; wdata = 16'h0000; wr = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0; wr = 1'b0;
    check("R9 set wins over clear", {13'd0, irq}, 16'h0001);
    wr_reg(A_STAT, 16'h0000);
    rd_reg(A_STAT, 16'h0002, "R9 marker consumed");
    wr_reg(A_STAT, 16'h0000);
    check("R10 irq drops with flag", {13'd0, irq}, 16'h0000);

    // capture on channel C
    wr_reg(A_IEN, 16'h0004);
    cap_mode = 3'b010;
    wr_reg(A_CNT, 16'h0100);
    cap[1] = 1'b1;
    @(negedge clk);
    check("R3 no capture after one edge", {13'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R3 no capture after two edges", {13'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R3 capture on third edge", {13'd0, irq}, 16'h0002);
    rd_reg(A_GRC,  16'h0100, "R3 captured value");
    rd_reg(A_STAT, 16'h0004, "R1 flag C at bit 2");
    wr_reg(A_CNT, 16'h0200);
    idle(4);
    rd_reg(A_GRC, 16'h0100, "R4 held input no recapture");
    rd_reg(A_STAT, 16'h0004, "R7 read before clear");
    wr_reg(A_STAT, 16'h0000);
    cap[1] = 1'b0;
    idle(3);
    cap[1] = 1'b1;
    idle(4);
    rd_reg(A_GRC,  16'h0200, "R3 second capture");
    rd_reg(A_STAT, 16'h0004, "R3 flag on second capture");

    // capture edge on a compare-mode channel
    cap[2] = 1'b1;
    idle(4);
    rd_reg(A_GRD,  16'h0000, "R4 compare-mode GR untouched");
    rd_reg(A_STAT, 16'h0004, "R4 compare-mode flag untouched");

    wr_reg(A_IEN, 16'h0000);
    check("R10 irq gated by enable", {13'd0, irq}, 16'h0000);

    // counter run and write priority
    cnt_en = 1'b1;
    idle(5);
    cnt_en = 1'b0;
    rd_reg(A_CNT, 16'h0205, "R13 five increments");
    cnt_en = 1'b1;
    wr_reg(A_CNT, 16'h0050);
    cnt_en = 1'b0;
    rd_reg(A_CNT, 16'h0050, "R13 write beats increment");

    idle(3);
    if (exp_q.size() != 0) check("R12 reads pending", 16'(exp_q.size()), 16'h0000);
    summary();
    $finish;
  end

  initial begin
    #2ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule